// File: doc/BRIEF.md
# I2C Register Bank Slave with Write Gate and Latched Status

This block is an I2C target that lets a host controller reach a bank of 8-bit registers. It samples SCL and SDA on the system clock and passes each line through a synchronizer and a three-sample majority vote. It then recognises START, repeated START and STOP. SDA is driven through an open-drain enable that is asserted only to pull the line low.

A host write sets an internal pointer and then stores data bytes at the pointer. A host read streams bytes from the pointer. The pointer advances after every data byte and wraps after the last address. Two further rules apply to the bank. The feature register only accepts writes while an enable bit in a second register is set. Two over-temperature status bits stay latched until a read sees that their condition has gone away. Writing the force-reset bit clears the whole bank. The register contents reach the rest of the chip as plain levels plus a one-cycle reset strobe.

Top module: `i2c_regbank_slave`

## Requirements
- R1: After reset `sda_oe` is 0, `mux_sel_o`, `sleep_o`, `feat_o` and `force_rst_o` are 0, and all stored registers read 0.
- R2: The block answers only to the 7-bit address 0x28, sent MSB first as byte 0x50 for a write or 0x51 for a read, and ACKs it by pulling SDA low in the ninth clock. Any other address byte gets no ACK, and every byte after it is ignored with no ACK until the next START.
- R3: In a write, the first byte after the address loads the pointer and each later byte is stored at the pointer. Every byte gets an ACK. The store takes effect at the SCL falling edge after the eighth data bit.
- R4: The pointer advances by one after each data byte and wraps from 0x0A to 0x00. A pointer byte above 0x0A loads 0x00. Writes to 0x00, 0x01, 0x09 and 0x0A are ignored, and reads of 0x09 and 0x0A return 0x00.
- R5: A read returns the byte at the pointer and advances the pointer. It keeps sending while the host ACKs, and releases SDA after a host NACK. A write of only the pointer followed by a repeated START gives a random read. A read with no pointer write starts at the current pointer.
- R6: Register 0x00 reads bit 5 as a constant 1 and bit 4 as the level of `wake_i`, with every other bit 0. Register 0x00 cannot be written.
- R7: Register 0x07 accepts a write only while bit 7 of register 0x08 is 1. A write to 0x07 while that bit is 0 leaves `feat_o` unchanged.
- R8: In register 0x01, bit 5 is set while `hot_ext_i` is high and bit 4 is set while `hot_int_i` is high. A read of 0x01 clears each bit only when its condition input is low at the moment the byte is loaded for sending.
- R9: A permitted write of a byte with bit 2 set to register 0x07 raises `force_rst_o` for exactly one clock. In the same clock it clears every register to 0, including the user flag bits 7:6 of 0x03 and 4:3 of 0x08, the status bits and the pointer.
- R10: `mux_sel_o` is register 0x03 bits 3:0, `sleep_o` is register 0x04 bit 7 and `feat_o` is register 0x07. `sda_oe` only rises while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw SCL level |
| sda_i | input | 1 | Raw SDA level (wired bus value) |
| sda_oe | output | 1 | 1 pulls SDA low |
| hot_ext_i | input | 1 | External over-temperature condition |
| hot_int_i | input | 1 | Internal over-temperature condition |
| wake_i | input | 1 | Qualified wake-pin status |
| mux_sel_o | output | 4 | Analog selection field of register 0x03 |
| sleep_o | output | 1 | Sleep request bit of register 0x04 |
| feat_o | output | 8 | Feature register 0x07 contents |
| force_rst_o | output | 1 | One-cycle strobe on forced reset |

## Verification
The bench builds the block with its default parameters: address 0x28, last pointer 0x0A and a two-stage synchronizer. With these values a five-byte write starting at 0x09 crosses both ignored addresses and wraps onto the read-only registers before it lands on 0x02. A two-byte read started at 0x0A also shows the wrap. SCL half periods of 40 clocks leave wide margins over the filter latency. This makes it possible to check the pointer and the write gate from the host side alone. The same holds for the clear-only-when-gone status rule and the forced reset.

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'h28,
  parameter int         LAST_REG    = 10,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       hot_ext_i,
  input  logic       hot_int_i,
  input  logic       wake_i,
  output logic [3:0] mux_sel_o,
  output logic       sleep_o,
  output logic [7:0] feat_o,
  output logic       force_rst_o
);
  localparam int              PW    = $clog2(LAST_REG + 1);
  localparam logic [PW-1:0]   LASTP = PW'(LAST_REG);
  localparam logic [7:0]      LAST8 = 8'(LAST_REG);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_RX, S_RACK, S_TX, S_TACK, S_IGN} st_t;

  function automatic logic maj3(input logic [2:0] v);
    return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
  endfunction

  logic [SYNC_STAGES-1:0] scl_s, sda_s;
  logic [2:0] scl_w, sda_w;
  logic scl_f, sda_f, scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_s <= '1; sda_s <= '1; scl_w <= '1; sda_w <= '1;
      scl_f <= 1'b1; sda_f <= 1'b1; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_s <= {scl_s[SYNC_STAGES-2:0], scl_i};
      sda_s <= {sda_s[SYNC_STAGES-2:0], sda_i};
      scl_w <= {scl_w[1:0], scl_s[SYNC_STAGES-1]};
      sda_w <= {sda_w[1:0], sda_s[SYNC_STAGES-1]};
      scl_f <= maj3(scl_w);
      sda_f <= maj3(sda_w);
      scl_q <= scl_f;
      sda_q <= sda_f;
    end

  wire scl_rise = scl_f & ~scl_q;
  wire scl_fall = ~scl_f & scl_q;
  wire start_ev = scl_f & scl_q & sda_q & ~sda_f;
  wire stop_ev  = scl_f & scl_q & ~sda_q & sda_f;

  st_t           state;
  logic [3:0]    cnt;
  logic [7:0]    sr, txb, rdata;
  logic          rw, first, mack, ext_f, int_f;
  logic [PW-1:0] ptr;
  logic [7:0]    rf [9];

  always_comb begin
    rdata = '0;
    if (ptr == PW'(0))      rdata = {2'b00, 1'b1, wake_i, 4'b0000};
    else if (ptr == PW'(1)) rdata = {2'b00, ext_f, int_f, 4'b0000};
    else if (ptr <= PW'(8)) rdata = rf[ptr];
  end

  wire [PW-1:0] nxt_ptr   = (ptr >= LASTP) ? '0 : ptr + 1'b1;
  wire          gate_open = rf[8][7];
  wire          tx_load   = scl_fall & (((state == S_AACK) & rw) | ((state == S_TACK) & mack));
  wire          rd_clr    = tx_load & (ptr == PW'(1));
  wire          wr_go     = scl_fall & (state == S_RX) & (cnt == 4'd8) & ~first;
  wire          wr_ok     = (ptr >= PW'(2)) & (ptr <= PW'(8)) & ((ptr != PW'(7)) | gate_open);
  wire          force_go  = wr_go & wr_ok & (ptr == PW'(7)) & sr[2];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE; cnt <= '0; sr <= '0; txb <= '0; rw <= 1'b0; first <= 1'b0;
      mack <= 1'b0; ext_f <= 1'b0; int_f <= 1'b0; ptr <= '0; sda_oe <= 1'b0;
      force_rst_o <= 1'b0;
      for (int i = 0; i < 9; i++) rf[i] <= '0;
    end else begin
      force_rst_o <= 1'b0;
      ext_f <= hot_ext_i | (ext_f & ~rd_clr);
      int_f <= hot_int_i | (int_f & ~rd_clr);
      if (start_ev) begin
        state <= S_ADDR; cnt <= '0; sda_oe <= 1'b0; first <= 1'b1;
      end else if (stop_ev) begin
        state <= S_IDLE; sda_oe <= 1'b0;
      end else begin
        case (state)
          S_ADDR:
            if (scl_rise) begin
              sr <= {sr[6:0], sda_f}; cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (sr[7:1] == DEV_ADDR) begin
                rw <= sr[0]; sda_oe <= 1'b1; state <= S_AACK;
              end else state <= S_IGN;
            end
          S_AACK:
            if (scl_fall) begin
              if (rw) begin
                txb <= {rdata[6:0], 1'b0}; sda_oe <= ~rdata[7]; cnt <= 4'd1;
                ptr <= nxt_ptr; state <= S_TX;
              end else begin
                sda_oe <= 1'b0; cnt <= '0; state <= S_RX;
              end
            end
          S_RX:
            if (scl_rise) begin
              sr <= {sr[6:0], sda_f}; cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              sda_oe <= 1'b1; state <= S_RACK;
              if (first) begin
                first <= 1'b0;
                ptr <= (sr > LAST8) ? '0 : sr[PW-1:0];
              end else begin
                if (wr_ok) rf[ptr] <= sr;
                ptr <= nxt_ptr;
                if (force_go) force_rst_o <= 1'b1;
              end
            end
          S_RACK:
            if (scl_fall) begin
              sda_oe <= 1'b0; cnt <= '0; state <= S_RX;
            end
          S_TX:
            if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_oe <= 1'b0; state <= S_TACK;
              end else begin
                sda_oe <= ~txb[7]; txb <= {txb[6:0], 1'b0}; cnt <= cnt + 4'd1;
              end
            end
          S_TACK:
            if (scl_rise) mack <= ~sda_f;
            else if (scl_fall) begin
              if (mack) begin
                txb <= {rdata[6:0], 1'b0}; sda_oe <= ~rdata[7]; cnt <= 4'd1;
                ptr <= nxt_ptr; state <= S_TX;
              end else state <= S_IGN;
            end
          default: ;
        endcase
      end
      if (force_go) begin
        for (int i = 0; i < 9; i++) rf[i] <= '0;
        ext_f <= 1'b0; int_f <= 1'b0; ptr <= '0;
      end
    end

  assign mux_sel_o = rf[3][3:0];
  assign sleep_o   = rf[4][7];
  assign feat_o    = rf[7];
endmodule

module i2c_regbank_slave_chk #(
  parameter int            PW    = 4,
  parameter logic [PW-1:0] LASTP = PW'(10)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_i,
  input logic          sda_oe,
  input logic          hot_ext_i,
  input logic          hot_int_i,
  input logic [7:0]    feat_o,
  input logic [3:0]    mux_sel_o,
  input logic          force_rst_o,
  input logic          gate_open,
  input logic          ext_flag,
  input logic          int_flag,
  input logic [PW-1:0] ptr
);
  assert_oe_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);
  assert_ptr_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= LASTP);
  assert_feat_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(feat_o) |-> (force_rst_o || $past(gate_open)));
  assert_force_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    force_rst_o |-> (feat_o == 8'h00 && mux_sel_o == 4'h0 && ptr == '0));
  assert_force_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    force_rst_o |=> !force_rst_o);
  assert_ext_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hot_ext_i |=> (ext_flag || force_rst_o));
  assert_int_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hot_int_i |=> (int_flag || force_rst_o));
endmodule

bind i2c_regbank_slave i2c_regbank_slave_chk #(.PW(PW), .LASTP(LASTP)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .hot_ext_i(hot_ext_i), .hot_int_i(hot_int_i), .feat_o(feat_o),
  .mux_sel_o(mux_sel_o), .force_rst_o(force_rst_o), .gate_open(gate_open),
  .ext_flag(ext_f), .int_flag(int_f), .ptr(ptr)
);

// File: tb/i2c_regbank_slave_test.sv
module i2c_regbank_slave_test;
  localparam int Q = 20;
  localparam int H = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic hot_ext = 1'b0, hot_int = 1'b0, wake = 1'b0;
  logic sda_oe, sleep_o, force_rst_o;
  logic [3:0] mux_sel_o;
  logic [7:0] feat_o;
  wire sda_bus = m_sda & ~sda_oe;
  int checks = 0, errors = 0, pulses = 0;

  always #4 clk = ~clk;

  i2c_regbank_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .hot_ext_i(hot_ext), .hot_int_i(hot_int), .wake_i(wake),
    .mux_sel_o(mux_sel_o), .sleep_o(sleep_o), .feat_o(feat_o), .force_rst_o(force_rst_o)
  );

  always @(posedge clk) if (force_rst_o) pulses++;

  task automatic wt(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start;
    m_sda = 1'b1; wt(Q); m_scl = 1'b1; wt(Q); m_sda = 1'b0; wt(Q); m_scl = 1'b0;
  endtask

  task automatic bus_stop;
    wt(Q); m_sda = 1'b0; wt(Q); m_scl = 1'b1; wt(Q); m_sda = 1'b1; wt(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      wt(Q); m_sda = b[i]; wt(Q); m_scl = 1'b1; wt(H); m_scl = 1'b0;
    end
    wt(Q); m_sda = 1'b1; wt(Q); m_scl = 1'b1; wt(Q); ack = ~sda_bus; wt(Q); m_scl = 1'b0;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      wt(Q); m_sda = 1'b1; wt(Q); m_scl = 1'b1; wt(Q); d[i] = sda_bus; wt(Q); m_scl = 1'b0;
    end
    wt(Q); m_sda = give_ack ? 1'b0 : 1'b1; wt(Q); m_scl = 1'b1; wt(H); m_scl = 1'b0;
    wt(Q); m_sda = 1'b1;
  endtask

  task automatic write_seq(input logic [7:0] p, input logic [7:0] d [], input string req);
    logic a;
    bus_start;
    send_byte(8'h50, a); chk({req, " addr ack"}, a, 1);
    send_byte(p, a);     chk({req, " ptr ack"}, a, 1);
    foreach (d[i]) begin
      send_byte(d[i], a); chk({req, " data ack"}, a, 1);
    end
    bus_stop;
  endtask

  task automatic read_at(input logic [7:0] p, output logic [7:0] d);
    logic a;
    bus_start;
    send_byte(8'h50, a);
    send_byte(p, a);
    bus_start;
    send_byte(8'h51, a);
    recv_byte(1'b0, d);
    bus_stop;
  endtask

  task automatic t_reset;
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 mux", mux_sel_o, 0);
    chk("R1 sleep", sleep_o, 0);
    chk("R1 feat", feat_o, 0);
    chk("R1 strobe", force_rst_o, 0);
  endtask

  task automatic t_bad_addr;
    logic a;
    bus_start;
    send_byte(8'hA0, a); chk("R2 wrong address nack", a, 0);
    send_byte(8'h03, a); chk("R2 ignored byte nack", a, 0);
    send_byte(8'h09, a); chk("R2 ignored data nack", a, 0);
    bus_stop;
    chk("R2 ignored write mux", mux_sel_o, 0);
  endtask

  task automatic t_write;
    write_seq(8'h02, '{8'h5A, 8'h07, 8'h80}, "R3");
    chk("R3 R10 mux", mux_sel_o, 4'h7);
    chk("R3 R10 sleep", sleep_o, 1);
  endtask

  task automatic t_read;
    logic a; logic [7:0] d;
    wake = 1'b1;
    bus_start;
    send_byte(8'h50, a); send_byte(8'h00, a);
    bus_start;
    send_byte(8'h51, a); chk("R5 read addr ack", a, 1);
    recv_byte(1'b1, d); chk("R6 reg0 wake high", d, 8'h30);
    recv_byte(1'b1, d); chk("R5 reg1", d, 8'h00);
    recv_byte(1'b1, d); chk("R5 reg2", d, 8'h5A);
    recv_byte(1'b0, d); chk("R5 reg3", d, 8'h07);
    bus_stop;
    chk("R5 released after nack", sda_oe, 0);
    bus_start;
    send_byte(8'h51, a);
    recv_byte(1'b0, d); chk("R5 current address read", d, 8'h80);
    bus_stop;
    wake = 1'b0;
    read_at(8'h00, d); chk("R6 reg0 wake low", d, 8'h20);
    write_seq(8'h00, '{8'hFF}, "R6");
    read_at(8'h00, d); chk("R6 reg0 not writable", d, 8'h20);
  endtask

  task automatic t_wrap;
    logic a; logic [7:0] d;
    write_seq(8'h09, '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h11}, "R4");
    read_at(8'h02, d); chk("R4 write wrapped to reg2", d, 8'h11);
    read_at(8'h01, d); chk("R4 reg1 not writable", d, 8'h00);
    wake = 1'b1;
    bus_start;
    send_byte(8'h50, a); send_byte(8'h0A, a);
    bus_start;
    send_byte(8'h51, a);
    recv_byte(1'b1, d); chk("R4 reg0A reads zero", d, 8'h00);
    recv_byte(1'b0, d); chk("R4 read wrap to reg0", d, 8'h30);
    bus_stop;
    wake = 1'b0;
    read_at(8'h0C, d); chk("R4 pointer above range loads 0", d, 8'h20);
  endtask

  task automatic t_gate;
    logic [7:0] d;
    write_seq(8'h07, '{8'h01}, "R7");
    chk("R7 closed gate feat", feat_o, 8'h00);
    write_seq(8'h08, '{8'h80}, "R7");
    write_seq(8'h07, '{8'h21}, "R7");
    chk("R7 open gate feat", feat_o, 8'h21);
    read_at(8'h07, d); chk("R7 readback", d, 8'h21);
  endtask

  task automatic t_status;
    logic [7:0] d;
    hot_ext = 1'b1; wt(5); hot_ext = 1'b0;
    read_at(8'h01, d); chk("R8 ext latched", d, 8'h20);
    read_at(8'h01, d); chk("R8 ext cleared", d, 8'h00);
    hot_int = 1'b1; wt(5);
    read_at(8'h01, d); chk("R8 int set", d, 8'h10);
    read_at(8'h01, d); chk("R8 int held while present", d, 8'h10);
    hot_int = 1'b0; wt(5);
    read_at(8'h01, d); chk("R8 int still latched", d, 8'h10);
    read_at(8'h01, d); chk("R8 int cleared", d, 8'h00);
  endtask

  task automatic t_force;
    logic [7:0] d;
    write_seq(8'h03, '{8'hC7}, "R9");
    write_seq(8'h08, '{8'h98}, "R9");
    chk("R9 mux before", mux_sel_o, 4'h7);
    pulses = 0;
    write_seq(8'h07, '{8'h04}, "R9");
    chk("R9 one strobe", pulses, 1);
    chk("R9 mux cleared", mux_sel_o, 0);
    chk("R9 feat cleared", feat_o, 0);
    chk("R9 sleep cleared", sleep_o, 0);
    read_at(8'h03, d); chk("R9 reg3 flags cleared", d, 8'h00);
    read_at(8'h08, d); chk("R9 reg8 flags cleared", d, 8'h00);
    read_at(8'h02, d); chk("R9 reg2 cleared", d, 8'h00);
  endtask

  initial begin
    wt(5);
    rst_n = 1'b1;
    wt(10);
    t_reset;
    t_bad_addr;
    t_write;
    t_read;
    t_wrap;
    t_gate;
    t_status;
    t_force;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule